// File: doc/BRIEF.md
# E-Paper Panel Power-Up and Reset Sequencer

This block brings an e-paper timing controller out of power-off and into a state where it accepts serial frame data. A single start pulse turns the panel supply on. The block then keeps every line it owns low while the supply settles. Next it moves the reset (or power-on) pin and the chip select through a fixed, timed order. When the last wait ends, it gives a one-cycle ready strobe and releases the serial data and clock lines to the frame transmitter.

All waits are set as parameters in milliseconds. A prescaler turns the system clock into millisecond steps. It restarts at the start of every phase, so each phase lasts exactly its parameter times the number of clocks per millisecond.

A power-down request drives all controlled lines low for a bounded hold time. It then drops the supply enable and returns the block to idle.

There is one parameter for the panel family. The small-panel build pulses an active-low reset. The large-panel build uses an active-high power-on pin, which rises once together with chip select.

This block has no data stream. Every port is a plain level or a one-cycle pulse, so there are no back-pressure rules.

Top module: `epd_pwr_seq`

## Requirements
- R1: During and right after reset, the outputs are: supply enable 0, reset/on pin 0, chip-select pin 0, serial hold 1, ready 0. The serial data and clock outputs are 0.
- R2: A start pulse in idle raises supply enable. For the settle time, the reset/on pin and the chip-select pin stay low and serial hold stays high. The settle time is 10 ms in the small-panel build and 20 ms in the large-panel build.
- R3: In the small-panel build, settle is followed by three steps. First, reset and chip select are both high for the pulse-high time (5 ms by default). Then reset is low, with chip select still high, for the pulse-low time (5 ms). Then reset rises again.
- R4: After the reset/on pin has risen for the last time, it and chip select stay high for the reset-to-select time (19 ms by default). Only then does chip select go low.
- R5: Chip select then stays low, with the serial lines still held, for the effective select-to-data time. This time is the largest of: the parameter, 1 ms, and the combined minimum less the reset-to-select time.
- R6: Ready is high for exactly one cycle: the first cycle in which serial hold is low. While serial hold is high, the serial data and clock outputs are 0. While it is low, they follow the transmitter inputs.
- R7: In the large-panel build there is no reset pulse. The on pin and chip select rise together right after settle.
- R8: A start pulse is ignored in every state except idle. It changes neither phase order nor phase length.
- R9: A power-down request is accepted in any state except idle and power-down. It drives the reset/on pin and chip select low and raises serial hold, with supply still on. This lasts for the hold time, clamped to 1..500 ms. Then supply enable falls and the block is idle.
- R10: Each timed phase lasts exactly its millisecond count times CLK_HZ/1000 clock cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Power-up request pulse, honoured only in idle |
| pwr_down_i | input | 1 | Power-down request pulse |
| tx_si_i | input | 1 | Serial data from the frame transmitter |
| tx_sclk_i | input | 1 | Serial clock from the frame transmitter |
| supply_en_o | output | 1 | Panel supply enable |
| rst_on_o | output | 1 | Reset pin (small build) or power-on pin (large build) |
| cs_n_o | output | 1 | Chip-select pin level |
| si_o | output | 1 | Serial data to the panel, forced low while held |
| sclk_o | output | 1 | Serial clock to the panel, forced low while held |
| serial_hold_o | output | 1 | High while this block owns the serial lines |
| ready_o | output | 1 | One-cycle strobe: the transmitter may begin |

## Verification
The hardest situations to reach from the ports are a power-down that cuts a sequence short partway through, and a start pulse that arrives while a phase is already counting. Both must leave phase lengths and order untouched.

The stimulus runs a first full power-up with start pulses injected during settle, during the select-to-data wait and during power-down. It then runs a second power-up that is stopped during the reset-to-select wait.

A scoreboard holds the expected pin patterns and their lengths in cycles, and compares them with the observed output segments. A small combined minimum is set on the bench so that the select-to-data clamp changes the wait actually used.

// File: rtl/epd_pwr_pkg.sv
package epd_pwr_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETTLE,
    ST_RST_HI,
    ST_RST_LO,
    ST_RST_WAIT,
    ST_CS_WAIT,
    ST_ACTIVE,
    ST_PDOWN
  } pwr_state_e;

  function automatic int unsigned at_least_one(input int unsigned v);
    return (v < 1) ? 1 : v;
  endfunction

  function automatic int unsigned max2(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/epd_ms_prescaler.sv
module epd_ms_prescaler #(
  parameter int unsigned TICKS_PER_MS = 100000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear_i,
  output logic tick_o
);
  localparam int unsigned CW = (TICKS_PER_MS > 1) ? $clog2(TICKS_PER_MS) : 1;
  localparam logic [CW-1:0] LAST = CW'(TICKS_PER_MS - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt_q <= '0;
    else if (clear_i)        cnt_q <= '0;
    else if (cnt_q == LAST)  cnt_q <= '0;
    else                     cnt_q <= cnt_q + 1'b1;
  end

  // One pulse per millisecond, phase aligned to the last clear
  assign tick_o = (cnt_q == LAST);
endmodule

// File: rtl/epd_ms_timer.sv
module epd_ms_timer #(
  parameter int unsigned MS_W = 10
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load_i,
  input  logic [MS_W-1:0] load_ms_i,
  input  logic            tick_i,
  output logic            done_o
);
  logic [MS_W-1:0] rem_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                    rem_q <= '0;
    else if (load_i)               rem_q <= load_ms_i;
    else if (tick_i && rem_q != 0) rem_q <= rem_q - 1'b1;
  end

  // Done in the very cycle of the final millisecond tick
  assign done_o = tick_i && (rem_q == MS_W'(1));
endmodule

// File: rtl/epd_pwr_fsm.sv
module epd_pwr_fsm
  import epd_pwr_pkg::*;
#(
  parameter int unsigned LARGE_PANEL  = 0,
  parameter int unsigned MS_W         = 10,
  parameter int unsigned SETTLE_MS    = 10,
  parameter int unsigned RST_HIGH_MS  = 5,
  parameter int unsigned RST_LOW_MS   = 5,
  parameter int unsigned RST_TO_CS_MS = 19,
  parameter int unsigned CS_TO_SI_MS  = 1,
  parameter int unsigned PD_HOLD_MS   = 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start_i,
  input  logic            pwr_down_i,
  input  logic            done_i,
  output logic            load_o,
  output logic [MS_W-1:0] load_ms_o,
  output logic            supply_en_o,
  output logic            rst_on_o,
  output logic            cs_n_o,
  output logic            serial_hold_o,
  output logic            ready_o
);
  pwr_state_e state_q, state_d, after_settle;
  logic       ready_q;

  generate
    if (LARGE_PANEL != 0) begin : g_on_pin
      assign after_settle = ST_RST_WAIT;
    end else begin : g_rst_pulse
      assign after_settle = ST_RST_HI;
    end
  endgenerate

  function automatic logic [MS_W-1:0] phase_ms(input pwr_state_e s);
    case (s)
      ST_SETTLE:   return MS_W'(SETTLE_MS);
      ST_RST_HI:   return MS_W'(RST_HIGH_MS);
      ST_RST_LO:   return MS_W'(RST_LOW_MS);
      ST_RST_WAIT: return MS_W'(RST_TO_CS_MS);
      ST_CS_WAIT:  return MS_W'(CS_TO_SI_MS);
      ST_PDOWN:    return MS_W'(PD_HOLD_MS);
      default:     return '0;
    endcase
  endfunction

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_IDLE:     if (start_i) state_d = ST_SETTLE;
      ST_SETTLE:   if (done_i)  state_d = after_settle;
      ST_RST_HI:   if (done_i)  state_d = ST_RST_LO;
      ST_RST_LO:   if (done_i)  state_d = ST_RST_WAIT;
      ST_RST_WAIT: if (done_i)  state_d = ST_CS_WAIT;
      ST_CS_WAIT:  if (done_i)  state_d = ST_ACTIVE;
      ST_PDOWN:    if (done_i)  state_d = ST_IDLE;
      default:     state_d = state_q;
    endcase
    if (pwr_down_i && state_q != ST_IDLE && state_q != ST_PDOWN)
      state_d = ST_PDOWN;
  end

  assign load_o    = (state_d != state_q);
  assign load_ms_o = phase_ms(state_d);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      ready_q <= 1'b0;
    end else begin
      state_q <= state_d;
      ready_q <= (state_d == ST_ACTIVE) && (state_q != ST_ACTIVE);
    end
  end

  always_comb begin
    supply_en_o   = 1'b1;
    rst_on_o      = 1'b0;
    cs_n_o        = 1'b0;
    serial_hold_o = 1'b1;
    case (state_q)
      ST_IDLE:     supply_en_o = 1'b0;
      ST_RST_HI:   begin rst_on_o = 1'b1; cs_n_o = 1'b1; end
      ST_RST_LO:   cs_n_o = 1'b1;
      ST_RST_WAIT: begin rst_on_o = 1'b1; cs_n_o = 1'b1; end
      ST_CS_WAIT:  rst_on_o = 1'b1;
      ST_ACTIVE:   begin rst_on_o = 1'b1; serial_hold_o = 1'b0; end
      default:     ;
    endcase
  end

  assign ready_o = ready_q;
endmodule

// File: rtl/epd_pwr_seq.sv
module epd_pwr_seq
  import epd_pwr_pkg::*;
#(
  parameter int unsigned CLK_HZ          = 100_000_000,
  parameter int unsigned LARGE_PANEL     = 0,
  parameter int unsigned SETTLE_SMALL_MS = 10,
  parameter int unsigned SETTLE_LARGE_MS = 20,
  parameter int unsigned RST_HIGH_MS     = 5,
  parameter int unsigned RST_LOW_MS      = 5,
  parameter int unsigned RST_TO_CS_MS    = 19,
  parameter int unsigned CS_TO_SI_MS     = 1,
  parameter int unsigned MIN_SUM_MS      = 20,
  parameter int unsigned PD_MS           = 1,
  parameter int unsigned PD_MAX_MS       = 500
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  input  logic pwr_down_i,
  input  logic tx_si_i,
  input  logic tx_sclk_i,
  output logic supply_en_o,
  output logic rst_on_o,
  output logic cs_n_o,
  output logic si_o,
  output logic sclk_o,
  output logic serial_hold_o,
  output logic ready_o
);
  localparam int unsigned TICKS_PER_MS = at_least_one(CLK_HZ / 1000);
  localparam int unsigned SETTLE_EFF   =
    at_least_one((LARGE_PANEL != 0) ? SETTLE_LARGE_MS : SETTLE_SMALL_MS);
  localparam int unsigned RHI_EFF      = at_least_one(RST_HIGH_MS);
  localparam int unsigned RLO_EFF      = at_least_one(RST_LOW_MS);
  localparam int unsigned RCS_EFF      = at_least_one(RST_TO_CS_MS);
  localparam int unsigned CSD_SUM      =
    (MIN_SUM_MS > RCS_EFF) ? (MIN_SUM_MS - RCS_EFF) : 0;
  localparam int unsigned CSD_EFF      = max2(at_least_one(CS_TO_SI_MS), CSD_SUM);
  localparam int unsigned PD_EFF       =
    (PD_MS > PD_MAX_MS) ? PD_MAX_MS : at_least_one(PD_MS);
  localparam int unsigned MAX_MS       =
    max2(max2(max2(SETTLE_EFF, RHI_EFF), max2(RLO_EFF, RCS_EFF)), max2(CSD_EFF, PD_EFF));
  localparam int unsigned MS_W         = $clog2(MAX_MS + 1);

  logic            tick, done, load;
  logic [MS_W-1:0] load_ms;

  epd_ms_prescaler #(.TICKS_PER_MS(TICKS_PER_MS)) u_presc (
    .clk(clk), .rst_n(rst_n), .clear_i(load), .tick_o(tick)
  );

  epd_ms_timer #(.MS_W(MS_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .load_i(load), .load_ms_i(load_ms),
    .tick_i(tick), .done_o(done)
  );

  epd_pwr_fsm #(
    .LARGE_PANEL (LARGE_PANEL),
    .MS_W        (MS_W),
    .SETTLE_MS   (SETTLE_EFF),
    .RST_HIGH_MS (RHI_EFF),
    .RST_LOW_MS  (RLO_EFF),
    .RST_TO_CS_MS(RCS_EFF),
    .CS_TO_SI_MS (CSD_EFF),
    .PD_HOLD_MS  (PD_EFF)
  ) u_fsm (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .pwr_down_i(pwr_down_i),
    .done_i(done), .load_o(load), .load_ms_o(load_ms),
    .supply_en_o(supply_en_o), .rst_on_o(rst_on_o), .cs_n_o(cs_n_o),
    .serial_hold_o(serial_hold_o), .ready_o(ready_o)
  );

  assign si_o   = serial_hold_o ? 1'b0 : tx_si_i;
  assign sclk_o = serial_hold_o ? 1'b0 : tx_sclk_i;
endmodule

// File: rtl/epd_pwr_seq_chk.sv
module epd_pwr_seq_chk (
  input logic clk,
  input logic rst_n,
  input logic supply_en_o,
  input logic rst_on_o,
  input logic cs_n_o,
  input logic serial_hold_o,
  input logic si_o,
  input logic sclk_o,
  input logic ready_o
);
  // R6
  ready_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ready_o |=> !ready_o);

  // R6
  ready_released_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ready_o |-> (!serial_hold_o && supply_en_o && rst_on_o && !cs_n_o));

  // R2
  off_all_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !supply_en_o |-> (!rst_on_o && !cs_n_o && serial_hold_o && !si_o && !sclk_o));

  // R2
  rst_after_supply_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_on_o) |-> (supply_en_o && $past(supply_en_o)));

  // R4
  cs_after_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(cs_n_o) && rst_on_o) |-> $past(rst_on_o));

  // R9
  supply_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(supply_en_o) |-> $past(!rst_on_o && !cs_n_o && serial_hold_o));
endmodule

bind epd_pwr_seq epd_pwr_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .supply_en_o(supply_en_o), .rst_on_o(rst_on_o),
  .cs_n_o(cs_n_o), .serial_hold_o(serial_hold_o), .si_o(si_o),
  .sclk_o(sclk_o), .ready_o(ready_o)
);

// File: tb/test_epd_pwr_seq.sv
module epd_seg_mon (
  input logic       clk,
  input logic       rst_n,
  input logic [3:0] pat,
  input logic       ready,
  input logic       si,
  input logic       sclk,
  input logic       tx_si,
  input logic       tx_sclk
);
  logic [3:0] q_pat[$];
  int         q_len[$];
  string      q_tag[$];
  int checks = 0;
  int fails  = 0;
  int seg_len = 0;
  int n_ready = 0;
  bit started = 0;
  logic [3:0] prev;

  task automatic push(input logic [3:0] p, input int len, input string tag);
    q_pat.push_back(p); q_len.push_back(len); q_tag.push_back(tag);
  endtask

  task automatic close_seg(input logic [3:0] p, input int len);
    logic [3:0] ep; int el; string et;
    checks++;
    if (q_pat.size() == 0) begin
      fails++;
      $display("FAIL unexpected segment: actual pattern %b len %0d, expected none", p, len);
    end else begin
      ep = q_pat.pop_front(); el = q_len.pop_front(); et = q_tag.pop_front();
      if (p !== ep || (el != 0 && len != el)) begin
        fails++;
        $display("FAIL %s: actual pattern %b len %0d, expected pattern %b len %0d",
                 et, p, len, ep, el);
      end
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      if (started && pat !== prev) begin
        close_seg(prev, seg_len);
        seg_len = 0;
      end
      started = 1;
      prev = pat;
      seg_len++;
      if (ready) begin
        n_ready++;
        checks++;
        if (!(pat == 4'b1100 && seg_len == 1)) begin
          fails++;
          $display("FAIL R6 ready strobe: actual pattern %b seg cycle %0d, expected 1100 cycle 1",
                   pat, seg_len);
        end
      end
      if ({si, sclk} !== (pat[0] ? 2'b00 : {tx_si, tx_sclk})) begin
        fails++;
        $display("FAIL R6 serial lines: actual %b, expected %b", {si, sclk},
                 pat[0] ? 2'b00 : {tx_si, tx_sclk});
      end
    end
  end

  task automatic finish_check(input int exp_ready);
    checks++;
    if (q_pat.size() != 1 || q_pat[0] !== prev) begin
      fails++;
      $display("FAIL R9 final state: actual pattern %b left %0d, expected last item open",
               prev, q_pat.size());
    end
    checks++;
    if (n_ready != exp_ready) begin
      fails++;
      $display("FAIL R6 ready count: actual %0d, expected %0d", n_ready, exp_ready);
    end
  endtask
endmodule

module test_epd_pwr_seq;
  logic clk = 0;
  logic rst_n = 0;
  logic start_s = 0, pd_s = 0, start_l = 0, pd_l = 0;
  logic tx_si = 1, tx_sclk = 1;
  logic sup_s, rst_s, cs_s, si_s, sclk_s, hold_s, rdy_s;
  logic sup_l, rst_l, cs_l, si_l, sclk_l, hold_l, rdy_l;
  int own_checks = 0, own_fails = 0;

  always #5 clk = ~clk;

  // Small build: 10 clocks per ms, combined minimum 25 -> select-to-data 6 ms, hold 0 -> 1 ms
  epd_pwr_seq #(.CLK_HZ(10_000), .LARGE_PANEL(0), .CS_TO_SI_MS(0),
                .MIN_SUM_MS(25), .PD_MS(0)) i_epd_pwr_seq (
    .clk(clk), .rst_n(rst_n), .start_i(start_s), .pwr_down_i(pd_s),
    .tx_si_i(tx_si), .tx_sclk_i(tx_sclk), .supply_en_o(sup_s), .rst_on_o(rst_s),
    .cs_n_o(cs_s), .si_o(si_s), .sclk_o(sclk_s), .serial_hold_o(hold_s), .ready_o(rdy_s)
  );

  // Large build: on pin, select-to-data 60 ms, hold 3 ms
  epd_pwr_seq #(.CLK_HZ(10_000), .LARGE_PANEL(1), .CS_TO_SI_MS(60),
                .PD_MS(3)) i_epd_pwr_seq_l (
    .clk(clk), .rst_n(rst_n), .start_i(start_l), .pwr_down_i(pd_l),
    .tx_si_i(tx_si), .tx_sclk_i(tx_sclk), .supply_en_o(sup_l), .rst_on_o(rst_l),
    .cs_n_o(cs_l), .si_o(si_l), .sclk_o(sclk_l), .serial_hold_o(hold_l), .ready_o(rdy_l)
  );

  epd_seg_mon m_s (.clk(clk), .rst_n(rst_n), .pat({sup_s, rst_s, cs_s, hold_s}),
    .ready(rdy_s), .si(si_s), .sclk(sclk_s), .tx_si(tx_si), .tx_sclk(tx_sclk));
  epd_seg_mon m_l (.clk(clk), .rst_n(rst_n), .pat({sup_l, rst_l, cs_l, hold_l}),
    .ready(rdy_l), .si(si_l), .sclk(sclk_l), .tx_si(tx_si), .tx_sclk(tx_sclk));

  task automatic report();
    $display("TB_RESULT checks=%0d failures=%0d",
             own_checks + m_s.checks + m_l.checks, own_fails + m_s.fails + m_l.fails);
    $finish;
  endtask

  task automatic pulse(ref logic s);
    @(negedge clk); s = 1;
    @(negedge clk); s = 0;
  endtask

  task automatic chk_reset(input logic [5:0] act, input string which);
    own_checks++;
    if (act !== 6'b000100) begin
      own_fails++;
      $display("FAIL R1 reset state %s: actual %b, expected 000100", which, act);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    own_fails++;
    $display("FAIL watchdog: actual timeout, expected completion");
    report();
  end

  initial begin
    // Expected segments {supply, rst_on, cs_n, hold}; length 0 = not timed
    m_s.push(4'b0001, 0,   "R1 idle");
    m_s.push(4'b1001, 100, "R2 R8 settle");
    m_s.push(4'b1111, 50,  "R3 reset high");
    m_s.push(4'b1011, 50,  "R3 reset low");
    m_s.push(4'b1111, 190, "R4 reset to select");
    m_s.push(4'b1101, 60,  "R5 R8 select to data");
    m_s.push(4'b1100, 0,   "R6 active");
    m_s.push(4'b1001, 10,  "R9 R8 hold clamp");
    m_s.push(4'b0001, 0,   "R8 idle after hold");
    m_s.push(4'b1001, 100, "R10 settle run 2");
    m_s.push(4'b1111, 50,  "R3 reset high run 2");
    m_s.push(4'b1011, 50,  "R3 reset low run 2");
    m_s.push(4'b1111, 0,   "R9 cut short");
    m_s.push(4'b1001, 10,  "R9 hold after cut");
    m_s.push(4'b0001, 0,   "R9 idle");
    m_l.push(4'b0001, 0,   "R1 idle large");
    m_l.push(4'b1001, 200, "R2 settle large");
    m_l.push(4'b1111, 190, "R7 on pin to select");
    m_l.push(4'b1101, 600, "R5 select to data large");
    m_l.push(4'b1100, 0,   "R6 active large");
    m_l.push(4'b1001, 30,  "R9 hold large");
    m_l.push(4'b0001, 0,   "R9 idle large");

    repeat (4) @(negedge clk);
    chk_reset({sup_s, rst_s, cs_s, hold_s, rdy_s, si_s | sclk_s}, "small");
    chk_reset({sup_l, rst_l, cs_l, hold_l, rdy_l, si_l | sclk_l}, "large");
    rst_n = 1;
    repeat (3) @(negedge clk);

    // Run 1 (small) with ignored starts during settle, select wait and hold
    pulse(start_s);
    repeat (30) @(negedge clk);
    pulse(start_s);
    repeat (388) @(negedge clk);
    pulse(start_s);
    wait (rdy_s);
    repeat (20) @(negedge clk);
    pulse(pd_s);
    repeat (3) @(negedge clk);
    pulse(start_s);
    repeat (40) @(negedge clk);

    // Run 2 (small): power-down during reset-to-select wait
    pulse(start_s);
    repeat (260) @(negedge clk);
    pulse(pd_s);
    repeat (40) @(negedge clk);

    // Large build
    pulse(start_l);
    wait (rdy_l);
    repeat (10) @(negedge clk);
    pulse(pd_l);
    repeat (60) @(negedge clk);

    m_s.finish_check(1);
    m_l.finish_check(1);
    report();
  end
endmodule